// File: doc/BRIEF.md
# Three-Wire Configuration Word Loader

This block takes configuration words from a host over a three-wire serial link made of a data line, a shift clock and a load strobe. All three lines are sampled by the block's own system clock. Each line passes through a synchronizer, and the block detects edges on the shift clock and the load strobe. Bits shift into a 23-bit word register. When the load strobe rises, the three low bits of the word (the bits shifted in last) choose one of four destination registers: the TX reference word, the TX divider word, the RX reference word or the RX divider word. The 20 bits above the control bits are the payload.

Each destination keeps its own field layout. The registered fields drive divider counters and option inputs elsewhere on the chip. A word with a reserved control code is refused, and so is a word whose divider fields fall outside their legal range. A refused word changes no register and sets a sticky error flag.

Top module: `tws_loader`

## Requirements
- R1: On each rising edge of `ser_clk` while `ser_le` is low, the word register shifts up one place and takes `ser_data` into bit 0. The first bit sent therefore ends up in bit 22 (MSB first), and bits 2:0 hold the last three bits sent.
- R2: On a rising edge of `ser_le`, an accepted word updates only the register chosen by word bits 1:0. The codes are 0 for TX reference, 1 for TX divider, 2 for RX reference and 3 for RX divider. No register changes at any other time.
- R3: Rising edges of `ser_clk` while `ser_le` is high do not change the word register.
- R4: A word with bit 2 set is a reserved code. Its load changes no register and sets `cfg_err`.
- R5: A reference word's payload (word bits 22:3) carries these fields: payload bits 13:0 give the reference divide value, bit 14 gives `*_cp_hi` (1 = high pump current, 0 = low), and bit 15 gives `*_pol_inv`. A TX reference word also carries `mon_en` in bit 16 and `mon_sel` in bits 18:17. A divide value below 8 is refused.
- R6: In a TX divider word, payload bits 4:0 give `tx_swallow` and bits 15:5 give `tx_prog`. A `tx_prog` value below 3 is refused.
- R7: In an RX divider word, payload bits 4:0 give `rx_swallow`, bits 14:5 give `rx_prog`, bits 18:15 give `rx_frac_num` and bit 19 gives `rx_mod8` (1 = modulus 8, 0 = modulus 5). The word is refused if `rx_prog` is below 34 or if `rx_frac_num` is not smaller than the modulus.
- R8: `cfg_err` stays high until reset. A refused word leaves every register unchanged, and later accepted words still load.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock |
| ser_le | input | 1 | Load strobe; a rising edge commits the word |
| tx_ref_div | output | 14 | TX reference divide value |
| tx_cp_hi | output | 1 | TX charge pump high-current select |
| tx_pol_inv | output | 1 | TX phase detector polarity invert |
| mon_en | output | 1 | Monitor output enable (0 = lock indication) |
| mon_sel | output | 2 | Monitor source select |
| rx_ref_div | output | 14 | RX reference divide value |
| rx_cp_hi | output | 1 | RX charge pump high-current select |
| rx_pol_inv | output | 1 | RX phase detector polarity invert |
| tx_swallow | output | 5 | TX swallow count |
| tx_prog | output | 11 | TX programmable count |
| rx_swallow | output | 5 | RX swallow count |
| rx_prog | output | 10 | RX programmable count |
| rx_frac_num | output | 4 | RX fractional numerator |
| rx_mod8 | output | 1 | RX fractional modulus select |
| cfg_err | output | 1 | Sticky refused-word flag |

## Verification
The bench tests each legality limit on both sides: reference value 7 against 8, TX count 2 against 3, RX count 33 against 34, and numerator 4 or 5 against modulus 5 and 7 or 8 against modulus 8. An off-by-one compare would either accept a refused word or flag a good one. All four reserved codes are sent with payloads that would otherwise be legal, so a decoder that ignored bit 2 would corrupt a register. Clock pulses sent while the strobe is high carry a different word, so a shifter that ignored the strobe would reload the wrong value. A long pseudo-random sweep compares every output against a field model after each load, which exposes a swapped field, a misrouted destination or a flag that does not stay set.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int WORD_W  = 23;
  localparam int CTRL_W  = 3;
  localparam int PAY_W   = WORD_W - CTRL_W;
  localparam int REF_W   = 14;
  localparam int REF_MIN = 8;
  localparam int TXA_W   = 5;
  localparam int TXN_W   = 11;
  localparam int TXN_MIN = 3;
  localparam int RXA_W   = 5;
  localparam int RXN_W   = 10;
  localparam int RXN_MIN = 34;
  localparam int FRAC_W  = 4;
  localparam int MOD_LO  = 5;
  localparam int MOD_HI  = 8;
  localparam int MSEL_W  = 2;

  typedef enum logic [1:0] {
    DST_TX_REF = 2'd0,
    DST_TX_DIV = 2'd1,
    DST_RX_REF = 2'd2,
    DST_RX_DIV = 2'd3
  } dst_e;

  typedef struct packed {
    logic [REF_W-1:0] div;
    logic             cp_hi;
    logic             pol_inv;
  } ref_cfg_t;

  typedef struct packed {
    logic [TXA_W-1:0] swallow;
    logic [TXN_W-1:0] prog;
  } tx_div_t;

  typedef struct packed {
    logic [RXA_W-1:0]  swallow;
    logic [RXN_W-1:0]  prog;
    logic [FRAC_W-1:0] num;
    logic              mod8;
  } rx_div_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;
    if (STAGES > 1) begin : g_multi
      always_comb pipe_d = {pipe_q[STAGES-2:0], din[g]};
    end else begin : g_single
      always_comb pipe_d = din[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
    end
    assign dout[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/tws_shift.sv
module tws_shift #(
  parameter int W = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] word
);
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word;
    if (en) word_d = {word[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else        word <= word_d;
  end
endmodule

// File: rtl/tws_decode.sv
module tws_decode
  import tws_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [3:0]        load,
  output logic              reject,
  output ref_cfg_t          ref_f,
  output logic              mon_en_f,
  output logic [MSEL_W-1:0] mon_sel_f,
  output tx_div_t           txd_f,
  output rx_div_t           rxd_f
);
  logic [PAY_W-1:0] pay;
  dst_e             dst;
  logic             legal;
  logic [FRAC_W:0]  modulus;

  assign pay = word[WORD_W-1:CTRL_W];
  assign dst = dst_e'(word[1:0]);

  assign ref_f.div     = pay[REF_W-1:0];
  assign ref_f.cp_hi   = pay[REF_W];
  assign ref_f.pol_inv = pay[REF_W+1];
  assign mon_en_f      = pay[REF_W+2];
  assign mon_sel_f     = pay[REF_W+2+MSEL_W:REF_W+3];

  assign txd_f.swallow = pay[TXA_W-1:0];
  assign txd_f.prog    = pay[TXA_W+TXN_W-1:TXA_W];

  assign rxd_f.swallow = pay[RXA_W-1:0];
  assign rxd_f.prog    = pay[RXA_W+RXN_W-1:RXA_W];
  assign rxd_f.num     = pay[RXA_W+RXN_W+FRAC_W-1:RXA_W+RXN_W];
  assign rxd_f.mod8    = pay[RXA_W+RXN_W+FRAC_W];

  assign modulus = rxd_f.mod8 ? (FRAC_W+1)'(MOD_HI) : (FRAC_W+1)'(MOD_LO);

  always_comb begin
    unique case (dst)
      DST_TX_REF, DST_RX_REF: legal = (ref_f.div >= REF_W'(REF_MIN));
      DST_TX_DIV:             legal = (txd_f.prog >= TXN_W'(TXN_MIN));
      default:                legal = (rxd_f.prog >= RXN_W'(RXN_MIN)) &&
                                      ({1'b0, rxd_f.num} < modulus);
    endcase
  end

  assign reject = word[CTRL_W-1] | ~legal;

  for (genvar g = 0; g < 4; g++) begin : g_load
    assign load[g] = ~reject & (word[1:0] == 2'(g));
  end
endmodule

// File: rtl/tws_loader.sv
module tws_loader
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              ser_le,
  output logic [REF_W-1:0]  tx_ref_div,
  output logic              tx_cp_hi,
  output logic              tx_pol_inv,
  output logic              mon_en,
  output logic [MSEL_W-1:0] mon_sel,
  output logic [REF_W-1:0]  rx_ref_div,
  output logic              rx_cp_hi,
  output logic              rx_pol_inv,
  output logic [TXA_W-1:0]  tx_swallow,
  output logic [TXN_W-1:0]  tx_prog,
  output logic [RXA_W-1:0]  rx_swallow,
  output logic [RXN_W-1:0]  rx_prog,
  output logic [FRAC_W-1:0] rx_frac_num,
  output logic              rx_mod8,
  output logic              cfg_err
);
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic [2:0] pin_s;
  logic       data_s, sclk_s, le_s;
  logic       sclk_q, le_q;
  logic       sclk_rise, le_rise, shift_en;

  tws_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_sn),
    .din  ({ser_le, ser_clk, ser_data}),
    .dout (pin_s)
  );
  assign data_s = pin_s[0];
  assign sclk_s = pin_s[1];
  assign le_s   = pin_s[2];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sclk_q <= 1'b0;
      le_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      le_q   <= le_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign le_rise   = le_s & ~le_q;
  assign shift_en  = sclk_rise & ~le_s;

  logic [WORD_W-1:0] word_q;

  tws_shift #(.W(WORD_W)) u_shift (
    .clk  (clk),
    .rst_n(rst_sn),
    .en   (shift_en),
    .din  (data_s),
    .word (word_q)
  );

  logic [3:0]        load_sel;
  logic              reject;
  ref_cfg_t          ref_f;
  logic              mon_en_f;
  logic [MSEL_W-1:0] mon_sel_f;
  tx_div_t           txd_f;
  rx_div_t           rxd_f;

  tws_decode u_dec (
    .word     (word_q),
    .load     (load_sel),
    .reject   (reject),
    .ref_f    (ref_f),
    .mon_en_f (mon_en_f),
    .mon_sel_f(mon_sel_f),
    .txd_f    (txd_f),
    .rxd_f    (rxd_f)
  );

  ref_cfg_t          tx_ref_q, tx_ref_d, rx_ref_q, rx_ref_d;
  logic              mon_en_q, mon_en_d;
  logic [MSEL_W-1:0] mon_sel_q, mon_sel_d;
  tx_div_t           tx_div_q, tx_div_d;
  rx_div_t           rx_div_q, rx_div_d;
  logic              err_q, err_d;

  always_comb begin
    tx_ref_d  = tx_ref_q;
    rx_ref_d  = rx_ref_q;
    mon_en_d  = mon_en_q;
    mon_sel_d = mon_sel_q;
    tx_div_d  = tx_div_q;
    rx_div_d  = rx_div_q;
    err_d     = err_q | (le_rise & reject);
    if (le_rise && load_sel[DST_TX_REF]) begin
      tx_ref_d  = ref_f;
      mon_en_d  = mon_en_f;
      mon_sel_d = mon_sel_f;
    end
    if (le_rise && load_sel[DST_TX_DIV]) tx_div_d = txd_f;
    if (le_rise && load_sel[DST_RX_REF]) rx_ref_d = ref_f;
    if (le_rise && load_sel[DST_RX_DIV]) rx_div_d = rxd_f;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      tx_ref_q  <= '0;
      rx_ref_q  <= '0;
      mon_en_q  <= 1'b0;
      mon_sel_q <= '0;
      tx_div_q  <= '0;
      rx_div_q  <= '0;
      err_q     <= 1'b0;
    end else begin
      tx_ref_q  <= tx_ref_d;
      rx_ref_q  <= rx_ref_d;
      mon_en_q  <= mon_en_d;
      mon_sel_q <= mon_sel_d;
      tx_div_q  <= tx_div_d;
      rx_div_q  <= rx_div_d;
      err_q     <= err_d;
    end
  end

  assign tx_ref_div  = tx_ref_q.div;
  assign tx_cp_hi    = tx_ref_q.cp_hi;
  assign tx_pol_inv  = tx_ref_q.pol_inv;
  assign mon_en      = mon_en_q;
  assign mon_sel     = mon_sel_q;
  assign rx_ref_div  = rx_ref_q.div;
  assign rx_cp_hi    = rx_ref_q.cp_hi;
  assign rx_pol_inv  = rx_ref_q.pol_inv;
  assign tx_swallow  = tx_div_q.swallow;
  assign tx_prog     = tx_div_q.prog;
  assign rx_swallow  = rx_div_q.swallow;
  assign rx_prog     = rx_div_q.prog;
  assign rx_frac_num = rx_div_q.num;
  assign rx_mod8     = rx_div_q.mod8;
  assign cfg_err     = err_q;
endmodule

// File: rtl/tws_loader_chk.sv
module tws_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        le_s,
  input logic        le_rise,
  input logic [22:0] word_q,
  input logic [13:0] tx_ref_div,
  input logic [13:0] rx_ref_div,
  input logic [10:0] tx_prog,
  input logic [9:0]  rx_prog,
  input logic        cfg_err
);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> ($stable(tx_ref_div) && $stable(rx_ref_div) &&
                  $stable(tx_prog) && $stable(rx_prog)));

  // R2
  tx_ref_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word_q[2:0] == 3'd0 && word_q[16:3] >= 14'd8)
      |=> (tx_ref_div == $past(word_q[16:3])));

  // R3
  no_shift_le_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_s |=> $stable(word_q));

  // R4
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && word_q[2]) |=> ($stable(tx_ref_div) && $stable(rx_ref_div) &&
                                $stable(tx_prog) && $stable(rx_prog) && cfg_err));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R5
  ref_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ref_div == 14'd0 || tx_ref_div >= 14'd8) &&
    (rx_ref_div == 14'd0 || rx_ref_div >= 14'd8));

  // R7
  rx_prog_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_prog == 10'd0 || rx_prog >= 10'd34);
endmodule

bind tws_loader tws_loader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .le_s      (le_s),
  .le_rise   (le_rise),
  .word_q    (word_q),
  .tx_ref_div(tx_ref_div),
  .rx_ref_div(rx_ref_div),
  .tx_prog   (tx_prog),
  .rx_prog   (rx_prog),
  .cfg_err   (cfg_err)
);

// File: tb/tws_loader_tb.sv
module tws_loader_tb;
  localparam int CLK_P  = 10;
  localparam int HOLD   = 4;
  localparam int N_RAND = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_le = 1'b0;
  logic [13:0] tx_ref_div, rx_ref_div;
  logic tx_cp_hi, tx_pol_inv, mon_en, rx_cp_hi, rx_pol_inv, rx_mod8, cfg_err;
  logic [1:0] mon_sel;
  logic [4:0] tx_swallow, rx_swallow;
  logic [10:0] tx_prog;
  logic [9:0] rx_prog;
  logic [3:0] rx_frac_num;

  int checks = 0;
  int errors = 0;

  // model state
  logic [13:0] m_tx_ref, m_rx_ref;
  logic m_tx_cp, m_tx_pol, m_mon_en, m_rx_cp, m_rx_pol, m_rx_m8, m_err;
  logic [1:0] m_mon_sel;
  logic [4:0] m_tx_a, m_rx_a;
  logic [10:0] m_tx_n;
  logic [9:0] m_rx_n;
  logic [3:0] m_rx_num;

  always #(CLK_P/2) clk = ~clk;

  tws_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le),
    .tx_ref_div(tx_ref_div), .tx_cp_hi(tx_cp_hi), .tx_pol_inv(tx_pol_inv),
    .mon_en(mon_en), .mon_sel(mon_sel), .rx_ref_div(rx_ref_div), .rx_cp_hi(rx_cp_hi),
    .rx_pol_inv(rx_pol_inv), .tx_swallow(tx_swallow), .tx_prog(tx_prog),
    .rx_swallow(rx_swallow), .rx_prog(rx_prog), .rx_frac_num(rx_frac_num),
    .rx_mod8(rx_mod8), .cfg_err(cfg_err)
  );

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, "tx_ref_div", 32'(tx_ref_div), 32'(m_tx_ref));
    chk(req, "tx_cp_hi", 32'(tx_cp_hi), 32'(m_tx_cp));
    chk(req, "tx_pol_inv", 32'(tx_pol_inv), 32'(m_tx_pol));
    chk(req, "mon_en", 32'(mon_en), 32'(m_mon_en));
    chk(req, "mon_sel", 32'(mon_sel), 32'(m_mon_sel));
    chk(req, "rx_ref_div", 32'(rx_ref_div), 32'(m_rx_ref));
    chk(req, "rx_cp_hi", 32'(rx_cp_hi), 32'(m_rx_cp));
    chk(req, "rx_pol_inv", 32'(rx_pol_inv), 32'(m_rx_pol));
    chk(req, "tx_swallow", 32'(tx_swallow), 32'(m_tx_a));
    chk(req, "tx_prog", 32'(tx_prog), 32'(m_tx_n));
    chk(req, "rx_swallow", 32'(rx_swallow), 32'(m_rx_a));
    chk(req, "rx_prog", 32'(rx_prog), 32'(m_rx_n));
    chk(req, "rx_frac_num", 32'(rx_frac_num), 32'(m_rx_num));
    chk(req, "rx_mod8", 32'(rx_mod8), 32'(m_rx_m8));
    chk(req, "cfg_err", 32'(cfg_err), 32'(m_err));
  endtask

  task automatic model_reset();
    m_tx_ref = '0; m_rx_ref = '0; m_tx_cp = 0; m_tx_pol = 0; m_mon_en = 0;
    m_mon_sel = '0; m_rx_cp = 0; m_rx_pol = 0; m_tx_a = '0; m_tx_n = '0;
    m_rx_a = '0; m_rx_n = '0; m_rx_num = '0; m_rx_m8 = 0; m_err = 0;
  endtask

  // field model taken from R2, R4..R8
  task automatic model_apply(input logic [22:0] w);
    logic [19:0] p;
    int modulus;
    p = w[22:3];
    modulus = p[19] ? 8 : 5;
    if (w[2]) m_err = 1;
    else case (w[1:0])
      2'd0: if (p[13:0] >= 8) begin
              m_tx_ref = p[13:0]; m_tx_cp = p[14]; m_tx_pol = p[15];
              m_mon_en = p[16]; m_mon_sel = p[18:17];
            end else m_err = 1;
      2'd1: if (p[15:5] >= 3) begin m_tx_a = p[4:0]; m_tx_n = p[15:5]; end
            else m_err = 1;
      2'd2: if (p[13:0] >= 8) begin
              m_rx_ref = p[13:0]; m_rx_cp = p[14]; m_rx_pol = p[15];
            end else m_err = 1;
      default: if (p[14:5] >= 34 && int'(p[18:15]) < modulus) begin
              m_rx_a = p[4:0]; m_rx_n = p[14:5]; m_rx_num = p[18:15]; m_rx_m8 = p[19];
            end else m_err = 1;
    endcase
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ser_le = 0; ser_clk = 0; ser_data = 0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(6);
    model_reset();
  endtask

  task automatic shift_bits(input logic [22:0] w);
    for (int i = 22; i >= 0; i--) begin
      ser_data = w[i];
      wait_n(HOLD);
      ser_clk = 1'b1;
      wait_n(HOLD);
      ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    wait_n(2*HOLD);
    ser_le = 1'b0;
    wait_n(HOLD);
  endtask

  task automatic send(input logic [22:0] w, input string req);
    shift_bits(w);
    pulse_le();
    model_apply(w);
    compare_all(req);
  endtask

  function automatic logic [22:0] w_ref(input logic [1:0] code, input logic [13:0] r,
      input logic cp, input logic pol, input logic me, input logic [1:0] ms);
    return {1'b0, ms, me, pol, cp, r, 1'b0, code};
  endfunction

  function automatic logic [22:0] w_tx(input logic [10:0] n, input logic [4:0] a);
    return {4'b0, n, a, 3'd1};
  endfunction

  function automatic logic [22:0] w_rx(input logic m8, input logic [3:0] num,
      input logic [9:0] n, input logic [4:0] a);
    return {m8, num, n, a, 3'd3};
  endfunction

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rs;
    do_reset();
    compare_all("R9");

    // R1 R5: legal reference words, MSB-first framing
    send(w_ref(2'd0, 14'd8, 1'b1, 1'b0, 1'b1, 2'd2), "R1 R5");
    send(w_ref(2'd2, 14'd16383, 1'b0, 1'b1, 1'b0, 2'd0), "R5");
    send(w_ref(2'd0, 14'h2A55, 1'b0, 1'b1, 1'b0, 2'd3), "R1");
    // R6: legal lower bound
    send(w_tx(11'd3, 5'd31), "R6");
    send(w_tx(11'd2047, 5'd0), "R6");
    // R7: legal bounds of each modulus
    send(w_rx(1'b0, 4'd4, 10'd34, 5'd0), "R7");
    send(w_rx(1'b1, 4'd7, 10'd1023, 5'd17), "R7");

    // R3: clock pulses while the strobe is high are ignored
    send(w_ref(2'd0, 14'd100, 1'b0, 1'b0, 1'b0, 2'd0), "R3");
    ser_le = 1'b1;
    wait_n(2*HOLD);
    shift_bits(w_ref(2'd0, 14'd300, 1'b1, 1'b1, 1'b1, 2'd1));
    ser_le = 1'b0;
    wait_n(HOLD);
    pulse_le();
    compare_all("R3");

    // R4: every reserved code, legal-looking payload
    for (int c = 4; c < 8; c++) begin
      send({w_ref(2'd0, 14'd500, 1'b1, 1'b1, 1'b1, 2'd3)} | 23'(c), "R4");
    end

    // R5 R6 R7: rejections at each boundary, fresh reset each time
    do_reset(); send(w_ref(2'd0, 14'd7, 1'b1, 1'b1, 1'b1, 2'd1), "R5");
    do_reset(); send(w_ref(2'd2, 14'd7, 1'b1, 1'b1, 1'b0, 2'd0), "R5");
    do_reset(); send(w_tx(11'd2, 5'd9), "R6");
    do_reset(); send(w_rx(1'b0, 4'd1, 10'd33, 5'd3), "R7");
    do_reset(); send(w_rx(1'b0, 4'd5, 10'd200, 5'd3), "R7");
    do_reset(); send(w_rx(1'b1, 4'd8, 10'd200, 5'd3), "R7");

    // R8: flag stays set while later words still load
    send(w_tx(11'd77, 5'd12), "R8");
    send(w_ref(2'd2, 14'd999, 1'b1, 1'b0, 1'b0, 2'd0), "R8");
    do_reset();
    compare_all("R9");

    // R2: pseudo-random sweep over all codes and payloads
    rs = 32'h1234_5677;
    for (int k = 0; k < N_RAND; k++) begin
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      send(rs[22:0], "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule